// File: doc/BRIEF.md
# Dual-Slope PWM Timer

This block is an 8-bit timer that counts up and then down and drives one symmetric pulse-width-modulated output. A divider turns the system clock into count steps, one every N enabled clocks, with N chosen by a 3-bit select code. The counter climbs from 0 to 255 and then falls back to 0. Each full up-down cycle takes 510 count steps, so the output frequency is the clock divided by N×510.

The output level changes where the count meets the active compare value. A match on the way up drives the level low, and a match on the way down drives it high. The compare value written by software goes first into a holding register. It becomes active only when the count arrives at 255, so a new duty cycle always starts at the top of the ramp. At the top of the ramp the output is forced to the level that an up-count match would give. This keeps the waveform symmetric around 0 when the compare value moves away from 255, and when an up-count match is skipped. A polarity input inverts the pin. A sticky flag marks each arrival at 0 until it is cleared.

Top module: `pcpwm_timer`

## Requirements
- R1: The select code sets the divide ratio: 0→1, 1→8, 2→32, 3→64, 4→128, 5→256, 6 and 7→1024. The count changes only on every N-th clock while `run_en` is high. While `run_en` is low the count, direction, output and flag hold, and the divider restarts from zero. The first step after `run_en` rises comes N clocks later.
- R2: The count moves one step per tick. It goes up by 1 until it reaches 255, then down by 1 until it reaches 0, then up again, so a full cycle is 510 ticks.
- R3: A write (`duty_we` high) stores `duty_val` in a holding register. The holding register is copied into the active compare value on the tick that brings the count to 255. A write in that same cycle takes effect one cycle later. Until the copy, a write has no effect on the output.
- R4: While the active compare value C satisfies 0 < C < 255, a tick that makes the count equal to C drives the internal level low if the step was upward and high if it was downward. Other ticks below 255 leave the level unchanged.
- R5: With C equal to 0 every tick drives the level low, and with C equal to 255 every tick drives it high. The level therefore stays constant for a whole cycle.
- R6: With C below 255, the tick that brings the count to 255 drives the level low even when no match occurred. This covers the first top of the ramp after C leaves 255, and a ramp on which the up-count match was skipped.
- R7: `pwm_out` equals the internal level when `pwm_inv` is 0 and its complement when `pwm_inv` is 1. The pin follows `pwm_inv` in the same cycle.
- R8: `wrap_flag` rises on the tick that brings the count to 0 and stays high until `wrap_clr`. If a clear and a new set fall in the same cycle, the set wins.
- R9: After reset the count is 0 and counting up, the level is low, the flag is 0, and the holding and active compare values are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run_en | input | 1 | Enables the divider and the counter |
| div_sel | input | 3 | Divide-ratio select code |
| duty_we | input | 1 | Write strobe for the holding compare register |
| duty_val | input | 8 | Compare value to write |
| pwm_inv | input | 1 | Output polarity, 1 inverts |
| wrap_clr | input | 1 | Clears the wrap flag |
| pwm_out | output | 1 | PWM output pin |
| count | output | 8 | Current counter value |
| wrap_flag | output | 1 | Sticky flag, set when the count reaches 0 |

## Verification
A wrong direction bit or a wrong divider count shows up on `count` at the very next tick. This is at most N clocks later, so the counter is compared with a reference on every cycle. A corrupted active compare value or output level often stays hidden until the next match or the next top of the ramp, up to 510 ticks away. For that reason each compare setting is held for more than one full cycle. That setting includes the extreme values and the change away from 255. A flag fault appears at the next arrival at 0, or at the first clear that comes after it.

// File: rtl/pcpwm_pkg.sv
package pcpwm_pkg;
    localparam int DIV_W = 10;

    function automatic logic [DIV_W-1:0] div_limit(input logic [2:0] sel);
        logic [DIV_W-1:0] lim;
        case (sel)
            3'd0:    lim = 10'd0;
            3'd1:    lim = 10'd7;
            3'd2:    lim = 10'd31;
            3'd3:    lim = 10'd63;
            3'd4:    lim = 10'd127;
            3'd5:    lim = 10'd255;
            default: lim = 10'd1023;
        endcase
        return lim;
    endfunction
endpackage

// File: rtl/pcpwm_divider.sv
module pcpwm_divider
    import pcpwm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_en,
    input  logic [2:0] div_sel,
    output logic       tick
);
    typedef struct packed {
        logic [DIV_W-1:0] pre;
    } div_s;

    div_s st_d, st_q;
    logic [DIV_W-1:0] lim;

    always_comb begin
        lim  = div_limit(div_sel);
        tick = run_en && (st_q.pre >= lim);
        st_d = st_q;
        if (!run_en || tick) st_d.pre = '0;
        else                 st_d.pre = st_q.pre + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/pcpwm_counter.sv
module pcpwm_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    output logic [W-1:0] cnt,
    output logic [W-1:0] cnt_nxt,
    output logic         step_up
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         up;
    } cnt_s;

    cnt_s st_d, st_q;

    always_comb begin
        st_d    = st_q;
        cnt_nxt = st_q.up ? st_q.cnt + 1'b1 : st_q.cnt - 1'b1;
        if (tick) begin
            st_d.cnt = cnt_nxt;
            st_d.up  = st_q.up ? (cnt_nxt != TOP) : (cnt_nxt == '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt <= '0;
            st_q.up  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt     = st_q.cnt;
    assign step_up = st_q.up;

    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(st_q.cnt)); // R1
    AST_UP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        tick && st_q.up |=> st_q.cnt == W'($past(st_q.cnt) + 1'b1)); // R2
    AST_DOWN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        tick && !st_q.up |=> st_q.cnt == W'($past(st_q.cnt) - 1'b1)); // R2
endmodule

// File: rtl/pcpwm_compare.sv
module pcpwm_compare #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [W-1:0] cnt_nxt,
    input  logic         step_up,
    input  logic         duty_we,
    input  logic [W-1:0] duty_val,
    output logic         wave
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    typedef struct packed {
        logic [W-1:0] hold;
        logic [W-1:0] act;
        logic         lvl;
    } cmp_s;

    cmp_s st_d, st_q;
    logic         load;
    logic [W-1:0] eff;

    always_comb begin
        st_d = st_q;
        load = tick && (cnt_nxt == TOP);
        eff  = load ? st_q.hold : st_q.act;
        if (duty_we) st_d.hold = duty_val;
        if (load)    st_d.act  = st_q.hold;
        if (tick) begin
            if (eff == '0)             st_d.lvl = 1'b0;
            else if (eff == TOP)       st_d.lvl = 1'b1;
            else if (cnt_nxt == TOP)   st_d.lvl = 1'b0;
            else if (cnt_nxt == eff)   st_d.lvl = !step_up;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wave = st_q.lvl;

    AST_ACT_ONLY_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(st_q.act)); // R3
    AST_FULL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        tick && !load && st_q.act == TOP |=> st_q.lvl); // R5
    AST_FULL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        tick && !load && st_q.act == '0 |=> !st_q.lvl); // R5
    AST_TOP_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
        load && st_q.hold != TOP |=> !st_q.lvl); // R6
endmodule

// File: rtl/pcpwm_timer.sv
module pcpwm_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_en,
    input  logic [2:0]   div_sel,
    input  logic         duty_we,
    input  logic [W-1:0] duty_val,
    input  logic         pwm_inv,
    input  logic         wrap_clr,
    output logic         pwm_out,
    output logic [W-1:0] count,
    output logic         wrap_flag
);
    typedef struct packed {
        logic flag;
    } top_s;

    top_s st_d, st_q;
    logic         tick;
    logic [W-1:0] cnt_nxt;
    logic         step_up;
    logic         wave;

    pcpwm_divider u_div (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .div_sel(div_sel), .tick(tick)
    );

    pcpwm_counter #(.W(W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .cnt(count), .cnt_nxt(cnt_nxt), .step_up(step_up)
    );

    pcpwm_compare #(.W(W)) u_cmp (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_nxt(cnt_nxt),
        .step_up(step_up), .duty_we(duty_we), .duty_val(duty_val), .wave(wave)
    );

    always_comb begin
        st_d = st_q;
        if (tick && cnt_nxt == '0) st_d.flag = 1'b1;
        else if (wrap_clr)         st_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wrap_flag = st_q.flag;
    assign pwm_out   = wave ^ pwm_inv;

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_flag && !wrap_clr |=> wrap_flag); // R8
    AST_FLAG_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wrap_flag) |-> count == '0); // R8
endmodule

// File: tb/sim_pcpwm_timer.sv
module sim_pcpwm_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run_en = 1'b0;
    logic [2:0] div_sel = 3'd0;
    logic       duty_we = 1'b0;
    logic [7:0] duty_val = 8'd0;
    logic       pwm_inv = 1'b0;
    logic       wrap_clr = 1'b0;
    logic       pwm_out;
    logic [7:0] count;
    logic       wrap_flag;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // reference state
    int m_pre = 0, m_cnt = 0, m_hold = 0, m_act = 0;
    bit m_up = 1, m_lvl = 0, m_flag = 0;

    always #5 clk = ~clk;

    pcpwm_timer u0 (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .div_sel(div_sel),
        .duty_we(duty_we), .duty_val(duty_val), .pwm_inv(pwm_inv),
        .wrap_clr(wrap_clr), .pwm_out(pwm_out), .count(count), .wrap_flag(wrap_flag)
    );

    function automatic int ratio(input int sel);
        case (sel)
            0: return 1;
            1: return 8;
            2: return 32;
            3: return 64;
            4: return 128;
            5: return 256;
            default: return 1024;
        endcase
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    // advance the reference by one clock using the inputs now applied
    task automatic model_adv();
        bit tk;
        int nx, eff;
        bit ld;
        tk = run_en && (m_pre >= ratio(div_sel) - 1);
        if (!run_en || tk) m_pre = 0; else m_pre++;
        nx = m_up ? m_cnt + 1 : m_cnt - 1;
        ld = tk && nx == 255;
        eff = ld ? m_hold : m_act;
        if (tk) begin
            if (eff == 0) m_lvl = 0;
            else if (eff == 255) m_lvl = 1;
            else if (nx == 255) m_lvl = 0;
            else if (nx == eff) m_lvl = !m_up;
        end
        if (ld) m_act = m_hold;
        if (duty_we) m_hold = duty_val;
        if (tk && nx == 0) m_flag = 1;
        else if (wrap_clr) m_flag = 0;
        if (tk) begin
            m_cnt = nx;
            if (m_up && nx == 255) m_up = 0;
            else if (!m_up && nx == 0) m_up = 1;
        end
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) begin
            string tc, tp;
            model_adv();
            @(negedge clk);
            tc = (div_sel != 0 || !run_en) ? "R1" : "R2";
            if (m_act == 0 || m_act == 255) tp = "R5";
            else if (m_cnt == 255) tp = "R6";
            else if (m_hold != m_act) tp = "R3";
            else if (pwm_inv) tp = "R7";
            else tp = "R4";
            chk(tc, count, m_cnt);
            chk(tp, pwm_out, m_lvl ^ pwm_inv);
            chk("R8", wrap_flag, m_flag);
        end
    endtask

    task automatic wr(input int v);
        duty_we = 1; duty_val = v[7:0];
        run(1);
        duty_we = 0;
    endtask

    initial begin
        int hi, lo, seg, len;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        chk("R9", count, 0);
        chk("R9", pwm_out, 0);
        chk("R9", wrap_flag, 0);
        rst_n = 1;
        // reset compare is 0: output stays low for a full cycle
        run_en = 1;
        hi = 0;
        for (int i = 0; i < 600; i++) begin run(1); if (pwm_out) hi++; end
        chk("R9", hi, 0);
        // mid duty, N=1
        wr(100);
        run(1200);
        // full high at 255
        wr(255);
        run(520);
        lo = 0;
        for (int i = 0; i < 510; i++) begin run(1); if (!pwm_out) lo++; end
        chk("R5", lo, 0);
        // leave 255: forced low at top of ramp
        wr(50);
        while (m_cnt != 254 || !m_up) run(1);
        chk("R6", pwm_out, 1);
        run(1);
        chk("R6", count, 255);
        chk("R6", pwm_out, 0);
        run(600);
        // compare 0: full low
        wr(0);
        run(520);
        hi = 0;
        for (int i = 0; i < 510; i++) begin run(1); if (pwm_out) hi++; end
        chk("R5", hi, 0);
        // inverted polarity
        wr(128);
        pwm_inv = 1;
        run(1100);
        // clear and set in the same cycle: set wins
        wrap_clr = 1;
        while (!(m_cnt == 1 && !m_up)) run(1);
        run(1);
        chk("R8", wrap_flag, 1);
        run(3);
        chk("R8", wrap_flag, 0);
        wrap_clr = 0;
        pwm_inv = 0;
        // divider with N=8, enable gating
        run_en = 0; run(1);
        div_sel = 3'd1; run(3);
        run_en = 1;
        run(4200);
        run_en = 0; run(40);
        run_en = 1;
        // N=1024 briefly
        run_en = 0; run(1); div_sel = 3'd6; run(1); run_en = 1;
        run(3500);
        // random segments
        for (seg = 0; seg < 40; seg++) begin
            run_en = 0; run(1);
            div_sel = 3'($urandom_range(0, 2));
            run_en = 1;
            pwm_inv = 1'($urandom_range(0, 1));
            case ($urandom_range(0, 3))
                0: wr(0);
                1: wr(255);
                default: wr($urandom_range(1, 254));
            endcase
            len = $urandom_range(300, 2000);
            for (int k = 0; k < len; k++) begin
                wrap_clr = ($urandom_range(0, 15) == 0);
                if ($urandom_range(0, 199) == 0) wr($urandom_range(0, 255));
                else if ($urandom_range(0, 99) == 0) begin
                    run_en = 0; run($urandom_range(1, 20)); run_en = 1;
                end else run(1);
            end
            wrap_clr = 0;
        end
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule